// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog timer clocked by a slow reference clock. Its internal count is split into a fixed 2^8 prescale part and an upper part. A 3-bit select field sets the timeout to one of eight lengths, from 2^8 to 2^18 reference periods. Software must restart the count before it expires, either with the clear strobe or with the halt strobe. If the count expires, the block resets the device. During sleep or idle it resets only the program counter and stack pointer.

A 5-bit key field controls the watchdog. The watchdog counts only while the key holds one of two complementary codes. Writing any other code acts as a software-triggered reset: the count is cleared, and a device reset follows a short fixed delay. The key field then returns to its power-on code, so the watchdog is running again. Two sticky flags record what happened: one for timeouts and one for resets caused by the key field. Software clears both flags.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, all four outputs are low. The key field holds 01010b, so the watchdog is counting. The select field holds 000.
- R2: The key codes 01010b and 10101b both keep the watchdog counting. Writing either code causes no reset.
- R3: A one-cycle clr_strobe or halt_strobe restarts the count from zero. If strobes arrive more often than the timeout length, no reset is ever produced.
- R4: The select field sets the timeout length L in reference periods. The encoding is 000=2^8, 001=2^10, 010=2^12, 011=2^14, 100=2^15, 101=2^16, 110=2^17, 111=2^18. The count starts after the clock edge that restarts it. The timeout output rises L edges after that restart edge.
- R5: If sleep_mode is low when the count expires, full_rst goes high for exactly one cycle and to_flag is set.
- R6: If sleep_mode is high when the count expires, part_rst goes high for exactly one cycle and full_rst stays low. to_flag is set.
- R7: Writing a key code other than 01010b or 10101b clears the count, and no timeout occurs while that code is held. full_rst goes high for one cycle, DELAY edges after the write edge (DELAY defaults to 4). On that same edge the key returns to 01010b and counting restarts from zero.
- R8: reg_rst_flag is set by the reset described in R7. It stays set until flag_clr is asserted. Timeouts never clear it.
- R9: A cycle with flag_clr high clears both to_flag and reg_rst_flag at the next edge.
- R10: A register write whose select value differs from the current one restarts the count from zero, so the new timeout is measured from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_key | input | 5 | Key (enable) field value to write |
| wr_sel | input | 3 | Timeout select value to write |
| clr_strobe | input | 1 | Clear-watchdog strobe |
| halt_strobe | input | 1 | Halt strobe; also restarts the count |
| sleep_mode | input | 1 | High while the device is in sleep or idle |
| flag_clr | input | 1 | Software clear of both status flags |
| full_rst | output | 1 | One-cycle full device reset request |
| part_rst | output | 1 | One-cycle program counter / stack pointer reset |
| to_flag | output | 1 | Sticky timeout status flag |
| reg_rst_flag | output | 1 | Sticky flag for a reset caused by the key field |

## Verification
The four outputs are registered and respond to inputs at different distances:
- A strobe, a write or a flag clear takes effect at the next edge.
- A timeout pulse appears L edges after the restart edge.
- A key-field reset pulse appears DELAY edges after the write edge.

The bench drives inputs only on falling edges and advances its behavioural model on each rising edge. It then compares all four outputs at the following falling edge, so every due cycle is checked exactly. Explicit checks on pulse counts, taken one edge before and one edge after the predicted pulse, pin down each timing boundary.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int PRE_BITS = 8,
  parameter int DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_key,
  input  logic [2:0] wr_sel,
  input  logic       clr_strobe,
  input  logic       halt_strobe,
  input  logic       sleep_mode,
  input  logic       flag_clr,
  output logic       full_rst,
  output logic       part_rst,
  output logic       to_flag,
  output logic       reg_rst_flag
);
  localparam int CW = PRE_BITS + 10;
  localparam int DW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [4:0] KEY_A = 5'b01010;
  localparam logic [4:0] KEY_B = 5'b10101;

  logic [4:0]    key;
  logic [2:0]    sel;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [DW-1:0] wait_cnt;
  int            tsh;

  wire enabled = (key == KEY_A) || (key == KEY_B);
  wire wr_bad  = wr_en && !((wr_key == KEY_A) || (wr_key == KEY_B));
  wire restart = clr_strobe || halt_strobe || wr_bad || (wr_en && (wr_sel != sel));

  always_comb begin
    if (sel < 3'd4) tsh = PRE_BITS + 2 * int'(sel);
    else            tsh = PRE_BITS + 3 + int'(sel);
  end

  assign last = (CW'(1) << tsh) - CW'(1);

  wire expire = enabled && !restart && (cnt == last);
  wire fire   = !enabled && (wait_cnt == DW'(DELAY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key          <= KEY_A;
      sel          <= 3'd0;
      cnt          <= '0;
      wait_cnt     <= '0;
      full_rst     <= 1'b0;
      part_rst     <= 1'b0;
      to_flag      <= 1'b0;
      reg_rst_flag <= 1'b0;
    end else begin
      full_rst     <= fire || (expire && !sleep_mode);
      part_rst     <= expire && sleep_mode;
      to_flag      <= expire || (to_flag && !flag_clr);
      reg_rst_flag <= fire || (reg_rst_flag && !flag_clr);

      if (!enabled || restart || expire) cnt <= '0;
      else                               cnt <= cnt + CW'(1);

      if (wr_bad || enabled || fire) wait_cnt <= '0;
      else                           wait_cnt <= wait_cnt + DW'(1);

      if (wr_en) begin
        key <= wr_key;
        sel <= wr_sel;
      end else if (fire) begin
        key <= KEY_A;
      end
    end
  end
endmodule

module wdt_keyed_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_strobe,
  input logic halt_strobe,
  input logic sleep_mode,
  input logic flag_clr,
  input logic full_rst,
  input logic part_rst,
  input logic to_flag,
  input logic reg_rst_flag
);
  a_r5_full_single: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |=> !full_rst);
  a_r6_part_single: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> !part_rst);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_rst && part_rst));
  a_r6_part_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |-> $past(sleep_mode));
  a_r6_part_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |-> to_flag);
  a_r3_strobe_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe || halt_strobe) |=> !part_rst);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rst_flag && !flag_clr) |=> reg_rst_flag);
  a_r5_full_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |-> (to_flag || reg_rst_flag));
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_strobe(clr_strobe), .halt_strobe(halt_strobe),
  .sleep_mode(sleep_mode), .flag_clr(flag_clr), .full_rst(full_rst),
  .part_rst(part_rst), .to_flag(to_flag), .reg_rst_flag(reg_rst_flag)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
  localparam int DELAY = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_key = 5'd0;
  logic [2:0] wr_sel = 3'd0;
  logic clr_strobe = 1'b0, halt_strobe = 1'b0, sleep_mode = 1'b0, flag_clr = 1'b0;
  wire full_rst, part_rst, to_flag, reg_rst_flag;

  wdt_keyed #(.PRE_BITS(8), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_sel(wr_sel),
    .clr_strobe(clr_strobe), .halt_strobe(halt_strobe), .sleep_mode(sleep_mode),
    .flag_clr(flag_clr), .full_rst(full_rst), .part_rst(part_rst),
    .to_flag(to_flag), .reg_rst_flag(reg_rst_flag)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, n_full = 0, n_part = 0;
  bit done = 1'b0;
  int m_key = 10, m_sel = 0, m_cnt = 0, m_wait = 0;
  bit m_full = 0, m_part = 0, m_to = 0, m_rrf = 0;
  int exps [8] = '{8, 10, 12, 14, 15, 16, 17, 18};

  function automatic bit ok_code(int k);
    return (k == 10) || (k == 21);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_model();
    int lim;
    bit v, wb, rs, nf, np;
    if (!rst_n) begin
      m_key = 10; m_sel = 0; m_cnt = 0; m_wait = 0;
      m_full = 0; m_part = 0; m_to = 0; m_rrf = 0;
    end else begin
      lim = 1 << exps[m_sel];
      v  = ok_code(m_key);
      wb = wr_en && !ok_code(int'(wr_key));
      rs = clr_strobe || halt_strobe || wb || (wr_en && int'(wr_sel) != m_sel);
      nf = 0; np = 0;
      if (flag_clr) begin m_to = 0; m_rrf = 0; end
      if (v) begin
        if (rs) m_cnt = 0;
        else if (m_cnt == lim - 1) begin
          m_cnt = 0; m_to = 1;
          if (sleep_mode) np = 1; else nf = 1;
        end else m_cnt++;
      end else begin
        m_cnt = 0;
        if (m_wait == DELAY - 1) begin
          nf = 1; m_key = 10; m_rrf = 1; m_wait = 0;
        end else m_wait++;
      end
      if (wr_en) begin
        m_sel = int'(wr_sel); m_key = int'(wr_key);
        if (wb) m_wait = 0;
      end
      m_full = nf; m_part = np;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    step_model();
    @(negedge clk);
    check("R5 R7 full_rst", int'(full_rst), int'(m_full));
    check("R6 part_rst", int'(part_rst), int'(m_part));
    check("R5 R9 to_flag", int'(to_flag), int'(m_to));
    check("R8 R9 reg_rst_flag", int'(reg_rst_flag), int'(m_rrf));
    n_full += int'(full_rst);
    n_part += int'(part_rst);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic strobe_clr();
    clr_strobe = 1'b1; tick(); clr_strobe = 1'b0;
  endtask

  task automatic strobe_halt();
    halt_strobe = 1'b1; tick(); halt_strobe = 1'b0;
  endtask

  task automatic write(int k, int s);
    wr_en = 1'b1; wr_key = 5'(k); wr_sel = 3'(s); tick(); wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int f0, p0;
    run(3);
    check("R1 full_rst in reset", int'(full_rst), 0);
    check("R1 flags in reset", int'(to_flag) + int'(reg_rst_flag), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4/R5: default select 000 expires after 2^8 edges
    f0 = n_full; run(255);
    check("R4 no timeout before 2^8", n_full - f0, 0);
    run(2);
    check("R5 one full reset on timeout", n_full - f0, 1);
    check("R5 timeout flag set", int'(to_flag), 1);
    clear_flags();
    check("R9 timeout flag cleared", int'(to_flag), 0);

    // R3: periodic clear and halt strobes
    strobe_clr(); f0 = n_full;
    for (int i = 0; i < 6; i++) begin
      run(200);
      if (i % 2 == 0) strobe_clr(); else strobe_halt();
    end
    check("R3 strobes prevent timeout", n_full - f0, 0);

    // R6: timeout in sleep gives partial reset only
    sleep_mode = 1'b1; strobe_clr(); f0 = n_full; p0 = n_part;
    run(257);
    check("R6 partial reset count", n_part - p0, 1);
    check("R6 no full reset in sleep", n_full - f0, 0);
    check("R6 timeout flag set", int'(to_flag), 1);
    sleep_mode = 1'b0; strobe_clr(); clear_flags();

    // R2: both valid keys keep counting without reset
    f0 = n_full;
    write(21, 0); run(100); write(10, 0); run(100);
    check("R2 valid key writes cause no reset", n_full - f0, 0);

    // R7/R8: invalid key
    strobe_clr(); run(150); f0 = n_full;
    write(0, 0);
    run(DELAY - 1);
    check("R7 no reset before delay", n_full - f0, 0);
    run(1);
    check("R7 reset after delay", n_full - f0, 1);
    check("R8 register reset flag set", int'(reg_rst_flag), 1);
    run(255);
    check("R7 counting restarts from zero", n_full - f0, 1);
    run(2);
    check("R7 timeout after key restored", n_full - f0, 2);
    check("R8 flag survives timeout", int'(reg_rst_flag), 1);
    clear_flags();
    check("R9 both flags cleared", int'(reg_rst_flag) + int'(to_flag), 0);

    // R10/R4: select change restarts the count
    strobe_clr(); run(200); f0 = n_full;
    write(10, 1);
    run(1023);
    check("R10 select change restarts count", n_full - f0, 0);
    run(2);
    check("R4 2^10 timeout", n_full - f0, 1);
    write(21, 3); f0 = n_full;
    run(16383);
    check("R4 no timeout before 2^14", n_full - f0, 0);
    run(2);
    check("R4 2^14 timeout", n_full - f0, 1);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule